// File: doc/BRIEF.md
# Embedded Interval and Watchdog Timer Unit

This block bundles three timers that share one free-running time base. A fixed-interval timer flags a status bit at a period chosen from four time-base taps. A programmable down-counter, loaded from a reload register, flags expiry and can reload itself. A watchdog escalates in stages each time its own tap period elapses: it first arms, then raises an interrupt, then issues a reset request of a kind chosen in the control register.

Software controls the unit through three write strobes that share one 32-bit data bus: control, status (write-one-to-clear) and counter reload. The control register, the status register and the live counter value are always visible on output ports. The time base advances on every cycle in which `tick` is high.

The watchdog is a four-state machine whose state is the pair {enabled, interrupt} in status bits 31:30. The states are QUIET (00), INTONLY (01), ARMED (10) and FIRED (11). When a watchdog period elapses, QUIET goes to ARMED and INTONLY goes to FIRED, and in both cases the enabled bit is set. ARMED goes to FIRED, which sets the interrupt status and may raise the interrupt. FIRED stays in FIRED and performs the reset action. A status write clears bits first, and a period event in the same cycle then acts on the cleared state.

Top module: `emb_timer_unit`

## Requirements
- R1: After reset, the control register, status register and counter read zero, and all interrupt and reset outputs are low.
- R2: A control write stores data bits 31:22 and clears bits 21:0. Every control write re-decides whether the counter runs. A counter that was stopped and becomes runnable restarts from the reload value.
- R3: When the FIT interrupt enable is set, the fixed-interval timer sets status bit 26 once every 2^(FIT_BASE+FIT_STEP*n) ticks, where n is control bits 25:24.
- R4: The FIT interrupt enable is control bit 23. A FIT event raises `fit_irq` only when this bit is set. Writing 1 to status bit 26 clears `fit_irq`.
- R5: A status write clears every bit among 31:26 whose data bit is 1. Data bits 25:0 have no effect.
- R6: A reload write of N loads the counter with N. While the counter runs, it decrements on each tick. On the Nth tick it expires: status bit 27 is set, and `pit_irq` is raised if control bit 26 is set.
- R7: The counter does not run when the reload value is 1 or less, or when control bit 26 is clear.
- R8: On expiry with control bit 22 set, the counter reloads and keeps counting. With bit 22 clear, it stops at zero.
- R9: Writing 1 to status bit 31 drops `pit_irq`. Writing 1 to status bit 27 alone leaves `pit_irq` unchanged.
- R10: On a watchdog period of 2^(WDG_BASE+WDG_STEP*m) ticks, where m is control bits 31:30, the following happens. From status 31:30 = 00 or 01, bit 31 is set. From 10, bit 30 is set, and `wdg_irq` is raised if control bit 27 is set.
- R11: On a watchdog period in state 11, control bits 29:28 are copied to status bits 29:28. Value 1 pulses `core_rst`, 2 pulses `chip_rst`, 3 pulses `sys_rst`, and 0 pulses nothing.
- R12: Each reset request lasts exactly one cycle, and at most one is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Time-base and counter advance enable |
| ctl_wr | input | 1 | Control register write strobe |
| sts_wr | input | 1 | Status register write-one-to-clear strobe |
| rld_wr | input | 1 | Counter reload write strobe |
| wdata | input | 32 | Write data shared by the three strobes |
| ctl_q | output | 32 | Control register contents |
| sts_q | output | 32 | Status register contents |
| pit_q | output | PIT_W | Current counter value |
| fit_irq | output | 1 | Fixed-interval interrupt request |
| pit_irq | output | 1 | Counter expiry interrupt request |
| wdg_irq | output | 1 | Watchdog interrupt request |
| core_rst | output | 1 | Core reset request pulse |
| chip_rst | output | 1 | Chip reset request pulse |
| sys_rst | output | 1 | System reset request pulse |

## Verification
The assertions assume that at most one write strobe is high in any cycle and that `wdata` is stable while a strobe is high. The bench raises each strobe alone for one cycle, with inputs changed on the falling edge. The property on the reset status holds only when no status write clears bits 29:28 in the cycle right after a reset pulse. The directed tests clear those bits only after a pulse has been observed, never in the cycle that follows it. Counter checks are made with `tick` held low during register writes, so every expected expiry cycle counts from a known load.

// File: rtl/emb_tmr_pkg.sv
package emb_tmr_pkg;
    typedef enum logic [1:0] {
        WD_QUIET   = 2'b00,
        WD_INTONLY = 2'b01,
        WD_ARMED   = 2'b10,
        WD_FIRED   = 2'b11
    } wd_state_e;

    typedef enum logic [1:0] {
        RK_NONE   = 2'd0,
        RK_CORE   = 2'd1,
        RK_CHIP   = 2'd2,
        RK_SYSTEM = 2'd3
    } rst_kind_e;

    localparam int CTL_KEEP_LO = 22;
    localparam int C_WD_PER    = 30;
    localparam int C_WD_RK     = 28;
    localparam int C_WD_IE     = 27;
    localparam int C_PIT_IE    = 26;
    localparam int C_FIT_PER   = 24;
    localparam int C_FIT_IE    = 23;
    localparam int C_PIT_AR    = 22;
    localparam int S_WD_EN     = 31;
    localparam int S_WD_INT    = 30;
    localparam int S_WD_RK     = 28;
    localparam int S_PIT       = 27;
    localparam int S_FIT       = 26;
endpackage

// File: rtl/tmr_timebase.sv
module tmr_timebase #(
    parameter int TB_W = 29
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    output logic [TB_W-1:0] tb
);
    always_ff @(posedge clk) begin
        if (!rst_n)    tb <= '0;
        else if (tick) tb <= tb + 1'b1;
    end
endmodule

// File: rtl/tmr_period_sel.sv
module tmr_period_sel #(
    parameter int BASE = 9,
    parameter int STEP = 4,
    localparam int KMAX = BASE + 3 * STEP
) (
    input  logic [KMAX-1:0] tb,
    input  logic            tick,
    input  logic [1:0]      sel,
    output logic            ev
);
    logic [3:0] hit;

    for (genvar g = 0; g < 4; g++) begin : g_tap
        localparam int K = BASE + STEP * g;
        assign hit[g] = &tb[K-1:0];
    end

    assign ev = tick & hit[sel];
endmodule

// File: rtl/tmr_pit.sv
module tmr_pit #(
    parameter int PIT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             ld_wr,
    input  logic [PIT_W-1:0] ld_val,
    input  logic             ctl_wr,
    input  logic             ie_new,
    input  logic             ie_cur,
    input  logic             auto_en,
    input  logic             clr_sts,
    input  logic             clr_irq,
    output logic [PIT_W-1:0] count,
    output logic             sts,
    output logic             irq
);
    logic [PIT_W-1:0] reload_q;
    logic             run_q;
    logic             expire;
    logic             ctl_run;

    assign expire  = run_q && tick && (count == PIT_W'(1)) && !ld_wr && !ctl_wr;
    assign ctl_run = (reload_q > PIT_W'(1)) && ie_new;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload_q <= '0;
            count    <= '0;
            run_q    <= 1'b0;
        end else if (ld_wr) begin
            reload_q <= ld_val;
            count    <= ld_val;
            run_q    <= (ld_val > PIT_W'(1)) && ie_cur;
        end else if (ctl_wr) begin
            if (ctl_run && !run_q) count <= reload_q;
            run_q <= ctl_run;
        end else if (expire) begin
            if (auto_en) begin
                count <= reload_q;
            end else begin
                count <= '0;
                run_q <= 1'b0;
            end
        end else if (run_q && tick) begin
            count <= count - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts <= 1'b0;
            irq <= 1'b0;
        end else begin
            sts <= (sts & ~clr_sts) | expire;
            irq <= (irq & ~clr_irq) | (expire & ie_cur);
        end
    end
endmodule

// File: rtl/tmr_wdog.sv
module tmr_wdog
    import emb_tmr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ev,
    input  logic [1:0] clr_state,
    input  logic [1:0] clr_rk,
    input  logic       irq_en,
    input  logic [1:0] rk_sel,
    output logic [1:0] state_bits,
    output logic [1:0] rk_sts,
    output logic       irq,
    output logic       core_rst,
    output logic       chip_rst,
    output logic       sys_rst
);
    wd_state_e state_q, base_s, next_s;
    logic      raise, fire;

    assign base_s = wd_state_e'(state_q & ~clr_state);

    always_comb begin
        next_s = base_s;
        raise  = 1'b0;
        fire   = 1'b0;
        if (ev) begin
            unique case (base_s)
                WD_QUIET:   next_s = WD_ARMED;
                WD_INTONLY: next_s = WD_FIRED;
                WD_ARMED: begin
                    next_s = WD_FIRED;
                    raise  = 1'b1;
                end
                WD_FIRED: begin
                    next_s = WD_FIRED;
                    fire   = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= WD_QUIET;
        else        state_q <= next_s;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rk_sts   <= RK_NONE;
            irq      <= 1'b0;
            core_rst <= 1'b0;
            chip_rst <= 1'b0;
            sys_rst  <= 1'b0;
        end else begin
            rk_sts   <= fire ? rk_sel : (rk_sts & ~clr_rk);
            irq      <= (irq & ~clr_state[0]) | (raise & irq_en);
            core_rst <= fire && (rk_sel == RK_CORE);
            chip_rst <= fire && (rk_sel == RK_CHIP);
            sys_rst  <= fire && (rk_sel == RK_SYSTEM);
        end
    end

    assign state_bits = state_q;
endmodule

// File: rtl/emb_timer_unit.sv
module emb_timer_unit
    import emb_tmr_pkg::*;
#(
    parameter int PIT_W    = 32,
    parameter int FIT_BASE = 9,
    parameter int FIT_STEP = 4,
    parameter int WDG_BASE = 17,
    parameter int WDG_STEP = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             ctl_wr,
    input  logic             sts_wr,
    input  logic             rld_wr,
    input  logic [31:0]      wdata,
    output logic [31:0]      ctl_q,
    output logic [31:0]      sts_q,
    output logic [PIT_W-1:0] pit_q,
    output logic             fit_irq,
    output logic             pit_irq,
    output logic             wdg_irq,
    output logic             core_rst,
    output logic             chip_rst,
    output logic             sys_rst
);
    localparam int FIT_MAX = FIT_BASE + 3 * FIT_STEP;
    localparam int WDG_MAX = WDG_BASE + 3 * WDG_STEP;
    localparam int TB_W    = (FIT_MAX > WDG_MAX) ? FIT_MAX : WDG_MAX;

    logic [TB_W-1:0] tb;
    logic [9:0]      ctl_r;
    logic [5:0]      clr;
    logic            fit_ev, wdg_ev;
    logic            fit_sts;
    logic            pit_sts;
    logic [1:0]      wd_bits, rk_sts;

    assign clr = sts_wr ? wdata[31:26] : 6'b0;

    always_ff @(posedge clk) begin
        if (!rst_n)      ctl_r <= '0;
        else if (ctl_wr) ctl_r <= wdata[31:CTL_KEEP_LO];
    end
    assign ctl_q = {ctl_r, 22'b0};

    tmr_timebase #(.TB_W(TB_W)) u_tb (
        .clk(clk), .rst_n(rst_n), .tick(tick), .tb(tb)
    );

    tmr_period_sel #(.BASE(FIT_BASE), .STEP(FIT_STEP)) u_fit_sel (
        .tb(tb[FIT_MAX-1:0]), .tick(tick),
        .sel(ctl_q[C_FIT_PER+1:C_FIT_PER]), .ev(fit_ev)
    );

    tmr_period_sel #(.BASE(WDG_BASE), .STEP(WDG_STEP)) u_wdg_sel (
        .tb(tb[WDG_MAX-1:0]), .tick(tick),
        .sel(ctl_q[C_WD_PER+1:C_WD_PER]), .ev(wdg_ev)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fit_sts <= 1'b0;
            fit_irq <= 1'b0;
        end else begin
            fit_sts <= (fit_sts & ~clr[S_FIT-26]) | fit_ev;
            fit_irq <= (fit_irq & ~clr[S_FIT-26]) | (fit_ev & ctl_q[C_FIT_IE]);
        end
    end

    tmr_pit #(.PIT_W(PIT_W)) u_pit (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .ld_wr(rld_wr), .ld_val(wdata[PIT_W-1:0]),
        .ctl_wr(ctl_wr), .ie_new(wdata[C_PIT_IE]),
        .ie_cur(ctl_q[C_PIT_IE]), .auto_en(ctl_q[C_PIT_AR]),
        .clr_sts(clr[S_PIT-26]), .clr_irq(clr[S_WD_EN-26]),
        .count(pit_q), .sts(pit_sts), .irq(pit_irq)
    );

    tmr_wdog u_wdog (
        .clk(clk), .rst_n(rst_n), .ev(wdg_ev),
        .clr_state(clr[5:4]), .clr_rk(clr[3:2]),
        .irq_en(ctl_q[C_WD_IE]), .rk_sel(ctl_q[C_WD_RK+1:C_WD_RK]),
        .state_bits(wd_bits), .rk_sts(rk_sts), .irq(wdg_irq),
        .core_rst(core_rst), .chip_rst(chip_rst), .sys_rst(sys_rst)
    );

    assign sts_q = {wd_bits, rk_sts, pit_sts, fit_sts, 26'b0};
endmodule

// File: rtl/emb_timer_unit_chk.sv
module emb_timer_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] ctl_q,
    input logic [31:0] sts_q,
    input logic        fit_irq,
    input logic        pit_irq,
    input logic        wdg_irq,
    input logic        core_rst,
    input logic        chip_rst,
    input logic        sys_rst
);
    assert_ctl_low_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q[21:0] == 22'b0);

    assert_fit_irq_src_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fit_irq) |-> sts_q[26] && ctl_q[23]);

    assert_pit_irq_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pit_irq) |-> sts_q[27]);

    assert_wdg_irq_src_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wdg_irq) |-> sts_q[30] && ctl_q[27]);

    assert_rst_from_fired_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (core_rst || chip_rst || sys_rst) |-> $past(sts_q[31:30]) == 2'b11);

    assert_rst_kind_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (core_rst || chip_rst || sys_rst) |->
            sts_q[29:28] == {chip_rst || sys_rst, core_rst || sys_rst});

    assert_rst_onehot_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({core_rst, chip_rst, sys_rst}));

    assert_rst_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (core_rst || chip_rst || sys_rst) |=> !(core_rst || chip_rst || sys_rst));
endmodule

bind emb_timer_unit emb_timer_unit_chk u_chk (
    .clk(clk), .rst_n(rst_n), .ctl_q(ctl_q), .sts_q(sts_q),
    .fit_irq(fit_irq), .pit_irq(pit_irq), .wdg_irq(wdg_irq),
    .core_rst(core_rst), .chip_rst(chip_rst), .sys_rst(sys_rst)
);

// File: tb/sim_emb_timer_unit.sv
module sim_emb_timer_unit;
    localparam int CLK_P = 10;
    localparam int PIT_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             tick = 1'b0;
    logic             ctl_wr = 1'b0, sts_wr = 1'b0, rld_wr = 1'b0;
    logic [31:0]      wdata = '0;
    logic [31:0]      ctl_q, sts_q;
    logic [PIT_W-1:0] pit_q;
    logic             fit_irq, pit_irq, wdg_irq, core_rst, chip_rst, sys_rst;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    emb_timer_unit #(
        .PIT_W(PIT_W), .FIT_BASE(2), .FIT_STEP(1), .WDG_BASE(4), .WDG_STEP(1)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .ctl_wr(ctl_wr), .sts_wr(sts_wr),
        .rld_wr(rld_wr), .wdata(wdata), .ctl_q(ctl_q), .sts_q(sts_q), .pit_q(pit_q),
        .fit_irq(fit_irq), .pit_irq(pit_irq), .wdg_irq(wdg_irq),
        .core_rst(core_rst), .chip_rst(chip_rst), .sys_rst(sys_rst)
    );

    always #(CLK_P/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; tick = 1'b0; ctl_wr = 1'b0; sts_wr = 1'b0; rld_wr = 1'b0;
        step(2);
        rst_n = 1'b1;
        step(1);
    endtask

    task automatic wr_ctl(logic [31:0] v);
        wdata = v; ctl_wr = 1'b1; step(1); ctl_wr = 1'b0;
    endtask

    task automatic wr_sts(logic [31:0] v);
        wdata = v; sts_wr = 1'b1; step(1); sts_wr = 1'b0;
    endtask

    task automatic wr_rld(logic [31:0] v);
        wdata = v; rld_wr = 1'b1; step(1); rld_wr = 1'b0;
    endtask

    task automatic wait_sts(int idx, int lim, output int at);
        at = -1;
        for (int i = 0; i < lim; i++) begin
            if (sts_q[idx]) begin
                at = cyc;
                break;
            end
            step(1);
        end
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 ctl", ctl_q, 32'h0);
        chk("R1 sts", sts_q, 32'h0);
        chk("R1 pit", 32'(pit_q), 32'h0);
        chk("R1 outs", {26'b0, fit_irq, pit_irq, wdg_irq, core_rst, chip_rst, sys_rst}, 32'h0);
    endtask

    task automatic t_ctl_mask();
        do_reset();
        wr_ctl(32'hFFFF_FFFF);
        chk("R2 ctl mask", ctl_q, 32'hFFC0_0000);
    endtask

    task automatic t_fit();
        int t0, t1;
        do_reset();
        wr_ctl(32'h0080_0000);
        tick = 1'b1;
        wait_sts(26, 20, t0);
        chk("R3 fit set", 32'(t0 >= 0), 32'd1);
        chk("R4 fit irq on", 32'(fit_irq), 32'd1);
        wr_sts(32'h03FF_FFFF);
        chk("R5 low bits ignored", 32'(sts_q[26]), 32'd1);
        wr_sts(32'h0400_0000);
        chk("R5 fit cleared", 32'(sts_q[26]), 32'd0);
        chk("R4 fit irq cleared", 32'(fit_irq), 32'd0);
        wait_sts(26, 20, t1);
        chk("R3 period 4", 32'(t1 - t0), 32'd4);
        wr_ctl(32'h0200_0000);
        wr_sts(32'h0400_0000);
        wait_sts(26, 40, t0);
        wr_sts(32'h0400_0000);
        wait_sts(26, 40, t1);
        chk("R3 period 16", 32'(t1 - t0), 32'd16);
        chk("R4 fit irq off", 32'(fit_irq), 32'd0);
        tick = 1'b0;
    endtask

    task automatic t_pit_once();
        do_reset();
        wr_ctl(32'h0400_0000);
        wr_rld(32'd5);
        chk("R6 loaded", 32'(pit_q), 32'd5);
        tick = 1'b1;
        step(4);
        chk("R6 count before", 32'(pit_q), 32'd1);
        chk("R6 no early expiry", 32'(sts_q[27]), 32'd0);
        step(1);
        chk("R6 expiry sts", 32'(sts_q[27]), 32'd1);
        chk("R6 expiry irq", 32'(pit_irq), 32'd1);
        chk("R8 stopped at zero", 32'(pit_q), 32'd0);
        step(3);
        chk("R8 stays zero", 32'(pit_q), 32'd0);
        tick = 1'b0;
        wr_sts(32'h0800_0000);
        chk("R5 pit sts cleared", 32'(sts_q[27]), 32'd0);
        chk("R9 irq kept by bit27", 32'(pit_irq), 32'd1);
        wr_sts(32'h8000_0000);
        chk("R9 irq dropped by bit31", 32'(pit_irq), 32'd0);
    endtask

    task automatic t_pit_auto();
        do_reset();
        wr_ctl(32'h0440_0000);
        wr_rld(32'd3);
        tick = 1'b1;
        step(3);
        chk("R8 first expiry", 32'(sts_q[27]), 32'd1);
        chk("R8 reloaded", 32'(pit_q), 32'd3);
        step(2);
        chk("R8 counting", 32'(pit_q), 32'd1);
        step(1);
        chk("R8 reloaded again", 32'(pit_q), 32'd3);
        tick = 1'b0;
    endtask

    task automatic t_pit_stop();
        do_reset();
        wr_ctl(32'h0400_0000);
        wr_rld(32'd1);
        tick = 1'b1;
        step(6);
        chk("R7 reload 1 idle", 32'(pit_q), 32'd1);
        chk("R7 reload 1 no expiry", 32'(sts_q[27]), 32'd0);
        tick = 1'b0;
        wr_ctl(32'h0);
        wr_rld(32'd4);
        tick = 1'b1;
        step(6);
        chk("R7 disabled idle", 32'(pit_q), 32'd4);
        chk("R7 disabled no expiry", 32'(sts_q[27]), 32'd0);
        tick = 1'b0;
        wr_ctl(32'h0400_0000);
        tick = 1'b1;
        step(4);
        chk("R2 ctl restarts counter", 32'(sts_q[27]), 32'd1);
        tick = 1'b0;
    endtask

    task automatic t_wdog_chip();
        int at;
        int seen;
        do_reset();
        wr_ctl(32'h2800_0000);
        tick = 1'b1;
        wait_sts(31, 40, at);
        chk("R10 armed", 32'(sts_q[31:30]), 32'd2);
        chk("R10 no irq yet", 32'(wdg_irq), 32'd0);
        wait_sts(30, 40, at);
        chk("R10 fired", 32'(sts_q[31:30]), 32'd3);
        chk("R10 irq", 32'(wdg_irq), 32'd1);
        seen = 0;
        for (int i = 0; i < 40; i++) begin
            if (core_rst || chip_rst || sys_rst) begin
                seen = 1;
                break;
            end
            step(1);
        end
        chk("R11 pulse seen", 32'(seen), 32'd1);
        chk("R11 chip kind", {29'b0, core_rst, chip_rst, sys_rst}, 32'b010);
        chk("R11 rk copied", 32'(sts_q[29:28]), 32'd2);
        step(1);
        chk("R12 single cycle", {29'b0, core_rst, chip_rst, sys_rst}, 32'b000);
        wr_sts(32'hC000_0000);
        chk("R5 wd bits cleared", 32'(sts_q[31:30]), 32'd0);
        seen = 0;
        at = -1;
        for (int i = 0; i < 40; i++) begin
            if (core_rst || chip_rst || sys_rst) seen = 1;
            if (sts_q[31]) begin
                at = cyc;
                break;
            end
            step(1);
        end
        chk("R10 rearmed", 32'(sts_q[31:30]), 32'd2);
        chk("R11 no reset after clear", 32'(seen), 32'd0);
        tick = 1'b0;
    endtask

    task automatic t_wdog_none();
        int seen;
        do_reset();
        tick = 1'b1;
        seen = 0;
        for (int i = 0; i < 60; i++) begin
            if (core_rst || chip_rst || sys_rst) seen++;
            step(1);
        end
        chk("R11 kind 0 no pulse", 32'(seen), 32'd0);
        chk("R11 kind 0 state", 32'(sts_q[31:28]), 32'hC);
        chk("R10 irq disabled", 32'(wdg_irq), 32'd0);
        tick = 1'b0;
    endtask

    initial begin
        t_reset();
        t_ctl_mask();
        t_fit();
        t_pit_once();
        t_pit_auto();
        t_pit_stop();
        t_wdog_chip();
        t_wdog_none();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R1 watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule